// File: doc/BRIEF.md
# SPI Byte Port with Receive Overrun Guard

This block is a byte-wide SPI peripheral core that can act as bus master or as a slave. The CPU sees two addresses: a status byte and one data address. A write to the data address goes straight into the single shift register. In master mode that write also starts an 8-bit exchange, with the clock generated at a fixed fraction of the system clock. In slave mode the same write only preloads the byte that the next exchange will send out. Each received byte is copied from the shift register into a separate read buffer. A CPU read of the data address always returns that buffer.

Every finished byte raises a completion flag. The flag is cleared by a two-step access: a status read that sees the flag set, and then any access to the data address. If another byte finishes while the flag is still set, the new byte is dropped. The byte already in the buffer stays, and an overrun flag is raised. A data write during an active master exchange is rejected and recorded in a collision flag. The shift register and the read buffer keep their contents through reset.

Top module: `spi_dr_core`

## Requirements
- R1: After reset the status byte reads 0x00, `bus_rdata` is 0x00 and `sck_o` is low.
- R2: In master mode, a data write while idle starts an exchange of exactly 8 SCK pulses at one quarter of the system clock. SCK idles low. The first rising SCK edge comes two clock edges after the write edge. MOSI carries the written byte MSB first, changing only on falling SCK edges.
- R3: In master mode, MISO is sampled on each rising SCK edge into the low end of the shift register. The finished byte moves into the read buffer. A data read (`bus_sel`=1) returns the buffer one cycle after the read.
- R4: Bit 7 of the status byte (`bus_sel`=0) is set at the clock edge that shifts the eighth bit, in both master and slave mode.
- R5: In slave mode, `sck_i` and `ss_n_i` pass through a two-stage synchronizer. Bits are taken only while the synchronized select is low: `mosi_i` is sampled on rising SCK and shifted on falling SCK. `miso_o` shows shift-register bit 7. A high select clears the partial bit count.
- R6: In slave mode, a data write preloads the shift register without producing any `sck_o` activity. The preloaded byte leaves on `miso_o` MSB first.
- R7: A status read that sees a flag set, followed by a read or write of the data address, clears that flag. This applies to completion (bit 7), collision (bit 6) and overrun (bit 5).
- R8: If a byte completes while the completion flag is set and is not being cleared in that cycle, the status byte gets overrun bit 5 set and the read buffer keeps its older byte.
- R9: A data write during a master exchange is ignored: the outgoing and received bytes are unchanged. It sets collision bit 6 of the status byte.
- R10: A clearing data access in the same cycle as a byte completion counts first. The new byte enters the buffer, the completion flag stays set, no overrun is raised, and that read itself returns the older byte.
- R11: Reset leaves the read buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| bus_sel | input | 1 | 0 = status byte, 1 = data address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Registered CPU read data |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock from external master |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |

## Verification
Byte completion and the flag-clearing data access can land on the same clock edge, and the outcome depends on which one is given priority. The bench starts a master exchange with the flag from an earlier byte still set. It then arms the clear with a status read and places the data read exactly on the edge that shifts the eighth bit. That read must return the older byte, the status must show completion without overrun, and the following data read must return the new byte. Repeating the sequence with the read one edge late must give an overrun and keep the old byte.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  // Status byte field positions, decoded by software.
  localparam int ST_DONE_BIT = 7;
  localparam int ST_WCOL_BIT = 6;
  localparam int ST_OVR_BIT  = 5;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } bus_sel_e;
endpackage

// File: rtl/spi_dr_mseq.sv
// Master sequencer: divides the system clock, drives SCK and emits
// sample / shift strobes for one byte.
module spi_dr_mseq #(
  parameter int DIV  = 4,
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic sample_stb,
  output logic shift_stb,
  output logic last_stb
);
  localparam int PW   = (DIV  > 2) ? $clog2(DIV)  : 1;
  localparam int BW   = (BITS > 2) ? $clog2(BITS) : 1;
  localparam logic [PW-1:0] PH_RISE = PW'(DIV/2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [BW-1:0] BC_LAST = BW'(BITS - 1);

  logic [PW-1:0] ph;
  logic [BW-1:0] bc;

  assign sample_stb = busy && (ph == PH_RISE);
  assign shift_stb  = busy && (ph == PH_LAST);
  assign last_stb   = shift_stb && (bc == BC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      ph   <= '0;
      bc   <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      ph   <= '0;
      bc   <= '0;
    end else if (busy) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (ph == PH_RISE) sck <= 1'b1;
      if (ph == PH_LAST) begin
        sck <= 1'b0;
        bc  <= (bc == BC_LAST) ? '0 : bc + 1'b1;
        if (bc == BC_LAST) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dr_sfront.sv
// Slave front end: synchronizes external SCK and select, finds the
// edges and counts bits of the current byte.
module spi_dr_sfront #(
  parameter int SYNC = 2,
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sck_in,
  input  logic ss_n_in,
  output logic sample_stb,
  output logic shift_stb,
  output logic last_stb
);
  localparam int BW = (BITS > 2) ? $clog2(BITS) : 1;
  localparam logic [BW-1:0] BC_LAST = BW'(BITS - 1);

  logic [SYNC-1:0] sck_pipe;
  logic [SYNC-1:0] ss_pipe;
  logic            sck_prev;
  logic [BW-1:0]   bc;
  logic            sck_s;
  logic            ss_s;

  generate
    for (genvar g = 0; g < SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            sck_pipe[g] <= 1'b0;
            ss_pipe[g]  <= 1'b1;
          end else begin
            sck_pipe[g] <= sck_in;
            ss_pipe[g]  <= ss_n_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            sck_pipe[g] <= 1'b0;
            ss_pipe[g]  <= 1'b1;
          end else begin
            sck_pipe[g] <= sck_pipe[g-1];
            ss_pipe[g]  <= ss_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign sck_s = sck_pipe[SYNC-1];
  assign ss_s  = ss_pipe[SYNC-1];

  assign sample_stb = enable && !ss_s &&  sck_s && !sck_prev;
  assign shift_stb  = enable && !ss_s && !sck_s &&  sck_prev;
  assign last_stb   = shift_stb && (bc == BC_LAST);

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || ss_s || !enable) bc <= '0;
    else if (shift_stb)         bc <= (bc == BC_LAST) ? '0 : bc + 1'b1;
  end
endmodule

// File: rtl/spi_dr_flags.sv
// Completion / overrun / collision flags with the two-step clear rule.
module spi_dr_flags (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic fire,
  input  logic wcol_set,
  output logic done_q,
  output logic ovr_q,
  output logic wcol_q,
  output logic accept
);
  logic arm_done, arm_ovr, arm_wcol;
  logic clr_done, clr_ovr, clr_wcol;
  logic done_eff;

  assign clr_done = arm_done && data_acc;
  assign clr_ovr  = arm_ovr  && data_acc;
  assign clr_wcol = arm_wcol && data_acc;

  // A clear in the completion cycle is honoured before the new byte.
  assign done_eff = done_q && !clr_done;
  assign accept   = fire && !done_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_done <= 1'b0;
      arm_ovr  <= 1'b0;
      arm_wcol <= 1'b0;
    end else if (data_acc) begin
      arm_done <= 1'b0;
      arm_ovr  <= 1'b0;
      arm_wcol <= 1'b0;
    end else if (stat_rd) begin
      if (done_q) arm_done <= 1'b1;
      if (ovr_q)  arm_ovr  <= 1'b1;
      if (wcol_q) arm_wcol <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (fire)          done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;

      if (fire && done_eff) ovr_q <= 1'b1;
      else if (clr_ovr)     ovr_q <= 1'b0;

      if (wcol_set)      wcol_q <= 1'b1;
      else if (clr_wcol) wcol_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_dr_core.sv
module spi_dr_core
  import spi_dr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o
);
  localparam int MSB = DATA_W - 1;

  logic data_wr, data_acc, stat_rd;
  logic m_busy, m_start, m_sample, m_shift, m_last;
  logic s_sample, s_shift, s_last;
  logic wcol_set, load, shift_stb, fire, accept;
  logic done_q, ovr_q, wcol_q;
  logic rx_bit;
  logic [DATA_W-1:0] shreg, rx_buf, new_byte, status_byte;

  assign data_wr  = bus_wr && (bus_sel == SEL_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_sel == SEL_DATA);
  assign stat_rd  = bus_rd && (bus_sel == SEL_STATUS);

  assign m_start  = data_wr && master_mode && !m_busy;
  assign wcol_set = data_wr && master_mode &&  m_busy;
  assign load     = data_wr && (!master_mode || !m_busy);

  spi_dr_mseq #(.DIV(CLK_DIV), .BITS(DATA_W)) i_mseq (
    .clk        (clk),
    .rst        (rst),
    .enable     (master_mode),
    .start      (m_start),
    .busy       (m_busy),
    .sck        (sck_o),
    .sample_stb (m_sample),
    .shift_stb  (m_shift),
    .last_stb   (m_last)
  );

  spi_dr_sfront #(.SYNC(SYNC_STAGES), .BITS(DATA_W)) i_sfront (
    .clk        (clk),
    .rst        (rst),
    .enable     (!master_mode),
    .sck_in     (sck_i),
    .ss_n_in    (ss_n_i),
    .sample_stb (s_sample),
    .shift_stb  (s_shift),
    .last_stb   (s_last)
  );

  spi_dr_flags i_flags (
    .clk      (clk),
    .rst      (rst),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .fire     (fire),
    .wcol_set (wcol_set),
    .done_q   (done_q),
    .ovr_q    (ovr_q),
    .wcol_q   (wcol_q),
    .accept   (accept)
  );

  assign shift_stb = m_shift || s_shift;
  assign fire      = m_last  || s_last;
  assign new_byte  = {shreg[MSB-1:0], rx_bit};

  always_ff @(posedge clk) begin
    if (rst)           rx_bit <= 1'b0;
    else if (m_sample) rx_bit <= miso_i;
    else if (s_sample) rx_bit <= mosi_i;
  end

  // Data path registers keep their contents through reset.
  always_ff @(posedge clk) begin
    if (load)           shreg <= bus_wdata;
    else if (shift_stb) shreg <= new_byte;
  end

  always_ff @(posedge clk) begin
    if (accept) rx_buf <= new_byte;
  end

  always_comb begin
    status_byte              = '0;
    status_byte[ST_DONE_BIT] = done_q;
    status_byte[ST_WCOL_BIT] = wcol_q;
    status_byte[ST_OVR_BIT]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= (bus_sel == SEL_DATA) ? rx_buf : status_byte;
  end

  assign mosi_o = shreg[MSB];
  assign miso_o = shreg[MSB];
endmodule

// File: rtl/spi_dr_checker.sv
module spi_dr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         master_mode,
  input logic         sck_o,
  input logic         fire,
  input logic         done_q,
  input logic         ovr_q,
  input logic         wcol_q,
  input logic         m_busy,
  input logic         data_wr,
  input logic         data_acc,
  input logic         stat_rd,
  input logic [W-1:0] rx_buf
);
  AST_DONE_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire |=> done_q);  // R4

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    (fire && done_q && !data_acc) |=> (ovr_q && $stable(rx_buf)));  // R8

  AST_WCOL_ON_BUSY_WR: assert property (@(posedge clk) disable iff (rst)
    (data_wr && master_mode && m_busy) |=> wcol_q);  // R9

  AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $past(m_busy));  // R2

  AST_SLAVE_NO_SCK: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && $past(!master_mode)) |-> !sck_o);  // R6

  AST_TWO_STEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && done_q) ##1 (data_acc && !fire) |=> !done_q);  // R7
endmodule

bind spi_dr_core spi_dr_checker #(.W(DATA_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .sck_o       (sck_o),
  .fire        (fire),
  .done_q      (done_q),
  .ovr_q       (ovr_q),
  .wcol_q      (wcol_q),
  .m_busy      (m_busy),
  .data_wr     (data_wr),
  .data_acc    (data_acc),
  .stat_rd     (stat_rd),
  .rx_buf      (rx_buf)
);

// File: tb/test_spi_dr_core.sv
`timescale 1ns/1ps
module test_spi_dr_core;
  logic clk = 1'b0;
  logic rst, master_mode, bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic sck_o, mosi_o, miso_i, sck_i, ss_n_i, mosi_i, miso_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 1'b0;

  logic [7:0] slv_pat = 8'h00;
  int fall_cnt = 0, fall_base = 0, rise_cnt = 0;
  logic [7:0] mosi_cap = 8'h00;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  spi_dr_core i_spi_dr_core (
    .clk(clk), .rst(rst), .master_mode(master_mode), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
  );

  // Remote slave model for master mode: shifts on falling SCK.
  always @(negedge sck_o) fall_cnt <= fall_cnt + 1;
  always @(posedge sck_o) begin
    mosi_cap <= {mosi_cap[6:0], mosi_o};
    rise_cnt <= rise_cnt + 1;
  end
  assign miso_i = slv_pat[3'(7 - (fall_cnt - fall_base))];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    bus_sel = sel; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic logic [7:0] reply(input logic [7:0] tx);
    return 8'((int'(tx) * 37 + 11) % 256);
  endfunction

  // Starts a master byte; returns the cycle number of the write edge.
  task automatic m_start(input logic [7:0] tx, input logic [7:0] pat, output int t0);
    slv_pat = pat; fall_base = fall_cnt;
    bus_write(tx);
    t0 = cyc;
  endtask

  task automatic slave_bit(input logic b, output logic got);
    mosi_i = b;
    repeat (4) @(negedge clk);
    got = miso_o;
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
    sck_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int t0, r0;
    rst = 1'b1; master_mode = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; sck_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(sck_o == 1'b0, "R1 sck", int'(sck_o), 0);
    chk(bus_rdata == 8'h00, "R1 rdata", int'(bus_rdata), 0);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R1 status", int'(d), 0);

    // R2 exact timing of first SCK edge and completion edge
    m_start(8'hC3, 8'h5A, t0);
    chk(sck_o == 1'b0, "R2 sck N0", int'(sck_o), 0);
    @(negedge clk);
    chk(sck_o == 1'b0, "R2 sck N1", int'(sck_o), 0);
    @(negedge clk);
    chk(sck_o == 1'b1, "R2 sck N2", int'(sck_o), 1);
    wait_cyc(t0 + 31);
    bus_read(1'b0, d);
    chk(d[7] == 1'b0, "R4 done before last edge", int'(d), 0);
    bus_read(1'b0, d);
    chk(d[7] == 1'b1, "R4 done at last edge", int'(d), 8'h80);
    bus_read(1'b1, d);
    chk(d == 8'h5A, "R3 first byte", int'(d), 8'h5A);

    // R2/R3/R4/R7 exhaustive sweep over transmitted bytes
    for (int v = 0; v < 256; v++) begin
      r0 = rise_cnt;
      m_start(8'(v), reply(8'(v)), t0);
      wait_cyc(t0 + 34);
      chk(mosi_cap == 8'(v), "R2 mosi byte", int'(mosi_cap), v);
      chk(rise_cnt - r0 == 8, "R2 sck pulses", rise_cnt - r0, 8);
      bus_read(1'b0, d);
      chk(d == 8'h80, "R4 status", int'(d), 8'h80);
      bus_read(1'b1, d);
      chk(d == reply(8'(v)), "R3 rx byte", int'(d), int'(reply(8'(v))));
      bus_read(1'b0, d);
      chk(d == 8'h00, "R7 cleared", int'(d), 0);
    end

    // R8 overrun keeps the older byte
    m_start(8'h11, 8'hA1, t0); wait_cyc(t0 + 34);
    m_start(8'h22, 8'hB2, t0); wait_cyc(t0 + 34);
    bus_read(1'b0, d);
    chk(d == 8'hA0, "R8 status", int'(d), 8'hA0);
    bus_read(1'b1, d);
    chk(d == 8'hA1, "R8 kept byte", int'(d), 8'hA1);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R7 ovr cleared", int'(d), 0);

    // R10 clear on the completion edge
    m_start(8'h33, 8'hC4, t0); wait_cyc(t0 + 34);
    m_start(8'h44, 8'hD5, t0);
    bus_read(1'b0, d);
    wait_cyc(t0 + 31);
    bus_read(1'b1, d);
    chk(d == 8'hC4, "R10 read returns older", int'(d), 8'hC4);
    wait_cyc(t0 + 36);
    bus_read(1'b0, d);
    chk(d == 8'h80, "R10 status no ovr", int'(d), 8'h80);
    bus_read(1'b1, d);
    chk(d == 8'hD5, "R10 new byte", int'(d), 8'hD5);
    bus_read(1'b0, d);

    // R8 variant: clear one edge late
    m_start(8'h55, 8'hE6, t0); wait_cyc(t0 + 34);
    m_start(8'h66, 8'hF7, t0);
    bus_read(1'b0, d);
    wait_cyc(t0 + 32);
    bus_read(1'b1, d);
    wait_cyc(t0 + 36);
    bus_read(1'b0, d);
    chk(d == 8'h20, "R8 late clear status", int'(d), 8'h20);
    bus_read(1'b1, d);
    chk(d == 8'hE6, "R8 late clear buffer", int'(d), 8'hE6);
    bus_read(1'b0, d);

    // R9 write collision
    m_start(8'h9C, 8'h3E, t0);
    wait_cyc(t0 + 5);
    bus_write(8'h01);
    wait_cyc(t0 + 34);
    chk(mosi_cap == 8'h9C, "R9 tx unchanged", int'(mosi_cap), 8'h9C);
    bus_read(1'b0, d);
    chk(d == 8'hC0, "R9 status", int'(d), 8'hC0);
    bus_read(1'b1, d);
    chk(d == 8'h3E, "R9 rx unchanged", int'(d), 8'h3E);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R7 wcol cleared", int'(d), 0);

    // Slave mode
    master_mode = 1'b0;
    @(negedge clk);
    // R5 aborted partial byte leaves no completion and no stale count
    bus_write(8'hFF);
    ss_n_i = 1'b0; repeat (4) @(negedge clk);
    for (int b = 0; b < 3; b++) slave_bit(1'b1, d2[0]);
    ss_n_i = 1'b1; repeat (6) @(negedge clk);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R5 partial no done", int'(d), 0);

    for (int i = 0; i < 24; i++) begin
      logic [7:0] sw, rx, cap;
      sw = 8'((i * 29 + 200) % 256);
      rx = 8'((i * 53 + 7) % 256);
      r0 = rise_cnt;
      bus_write(sw);
      ss_n_i = 1'b0; repeat (4) @(negedge clk);
      for (int b = 7; b >= 0; b--) begin
        slave_bit(rx[b], d2[0]);
        cap = {cap[6:0], d2[0]};
      end
      repeat (4) @(negedge clk);
      ss_n_i = 1'b1; repeat (4) @(negedge clk);
      chk(cap == sw, "R6 miso preload", int'(cap), int'(sw));
      chk(rise_cnt == r0, "R6 no sck_o", rise_cnt - r0, 0);
      bus_read(1'b0, d);
      chk(d == 8'h80, "R4 slave done", int'(d), 8'h80);
      bus_read(1'b1, d);
      chk(d == rx, "R5 slave rx", int'(d), int'(rx));
      bus_read(1'b0, d);
      chk(d == 8'h00, "R7 slave clear", int'(d), 0);
    end

    // R11 buffer survives reset (last slave byte: 23*53+7 = 1226 -> 0xCA)
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    bus_read(1'b0, d);
    chk(d == 8'h00, "R1 status after reset", int'(d), 0);
    bus_read(1'b1, d);
    chk(d == 8'hCA, "R11 buffer kept", int'(d), 8'hCA);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule